// File: doc/BRIEF.md
# DMA Channel Control and Status Register

This block holds the run-state of one descriptor-driven DMA channel. Software changes that state through a single 32-bit control word whose upper half is a per-bit write enable for the lower half. A write therefore touches only the bits it names, and several agents can share the register without a read-modify-write. The resulting state appears in a 16-bit status word. The status word goes to the channel sequencer and can be read back by software.

Each status bit follows its own ownership rule. Software alone drives run, pause and the four device-status bits. Software may raise flush and wake, and hardware lowers them. Only hardware moves dead, active and branch-taken. The active bit is never written directly. It is derived at every control write from the run, pause and wake requests.

The sequencer reports kill, stop, descriptor fetch, descriptor advance (with a branch-taken flag) and flush completion. The block answers with a flush request pulse and a kick pulse that tells the sequencer to resume fetching.

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset the status word, `flush_req`, `kick` and every read value are zero.
- R2: A write to the control index (0) changes only the lower-half bits whose mask bit (bit position + 16) is set. Run (bit 15), pause (bit 14) and device status (bits 3:0) change only through such writes. Mask bits for dead (11), active (10), branch-taken (8) and the unused bits 9 and 7:4 have no effect, and the unused bits always read zero.
- R3: A control write that masks run with a value of 0 clears both run and dead.
- R4: After any control write that leaves pause set or run clear, active is clear and `flush_req` pulses for one cycle. Active is never set while run is clear or pause is set.
- R5: A control write that leaves run set and pause clear sets active if its mask covers run or pause, or if it sets wake. Any other such write leaves active unchanged.
- R6: A control write with wake (bit 12) masked and set raises wake only if run is set after the write. `hw_fetch` clears wake.
- R7: A control write with flush (bit 13) masked and set raises the flush bit and pulses `flush_req`. The flush bit stays up until `hw_flush_done`.
- R8: `kick` pulses for one cycle, one cycle after a control write, exactly when active is set at the end of that write's cycle.
- R9: `hw_kill` sets dead and clears active. `hw_stop` clears active.
- R10: `hw_advance` loads branch-taken (bit 8) from `hw_taken`.
- R11: Reads at the control index and the status index (1) return the status word zero-extended to 32 bits. Other indices read zero. Writes to any index other than 0 are ignored.
- R12: When a control write and hardware events fall in the same cycle, the events are applied on top of the write's result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Word index of the register |
| bus_wdata | input | 32 | Write data: mask in [31:16], value in [15:0] |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| hw_kill | input | 1 | Fatal descriptor error |
| hw_stop | input | 1 | Stop descriptor executed |
| hw_fetch | input | 1 | Descriptor fetched |
| hw_advance | input | 1 | Descriptor pointer advanced |
| hw_taken | input | 1 | The advance was a taken branch |
| hw_flush_done | input | 1 | Device flush finished |
| status_o | output | 16 | Status word |
| flush_req | output | 1 | Device flush request pulse |
| kick | output | 1 | Resume-fetch pulse to sequencer |

## Verification
The embedded assertions are checked on every cycle. They cover the invariant that active implies run without pause, the rule that run never moves without a control write, the one-cycle effect of kill, fetch and flush completion, the link between a kick and active, and the rule that every control write ends in either a flush request or a runnable state. The exact masked-write results can only be shown by the bench's cycle-by-cycle model. The same holds for how a control write and a hardware event combine in one cycle, for the wake gating on run, and for the decode of read indices. The bench covers these with directed sequences and a long run of random writes and events.

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl #(
  parameter int AW       = 4,
  parameter int CTRL_IDX = 0,
  parameter int STAT_IDX = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          hw_kill,
  input  logic          hw_stop,
  input  logic          hw_fetch,
  input  logic          hw_advance,
  input  logic          hw_taken,
  input  logic          hw_flush_done,
  output logic [15:0]   status_o,
  output logic          flush_req,
  output logic          kick
);
  localparam int B_RUN = 15, B_PAU = 14, B_FLU = 13, B_WAK = 12;
  localparam int B_DED = 11, B_ACT = 10, B_BT = 8;
  localparam logic [AW-1:0] A_CTL = AW'(CTRL_IDX);
  localparam logic [AW-1:0] A_STA = AW'(STAT_IDX);

  logic [15:0] st, w, nxt, msk, val;
  logic        ctl_wr, w_flush;

  assign ctl_wr = bus_wr && (bus_addr == A_CTL);
  assign msk    = bus_wdata[31:16];
  assign val    = bus_wdata[15:0];

  always_comb begin
    w       = st;
    w_flush = 1'b0;
    if (ctl_wr) begin
      if (msk[B_RUN]) begin
        w[B_RUN] = val[B_RUN];
        if (!val[B_RUN]) w[B_DED] = 1'b0;
      end
      if (msk[B_WAK] && val[B_WAK] && w[B_RUN]) w[B_WAK] = 1'b1;
      if (msk[B_PAU]) w[B_PAU] = val[B_PAU];
      if (msk[B_FLU] && val[B_FLU]) begin
        w[B_FLU] = 1'b1;
        w_flush  = 1'b1;
      end
      w[3:0] = (st[3:0] & ~msk[3:0]) | (val[3:0] & msk[3:0]);
      if (w[B_PAU] || !w[B_RUN]) begin
        w[B_ACT] = 1'b0;
        w_flush  = 1'b1;
      end else if (msk[B_RUN] || msk[B_PAU] || (msk[B_WAK] && val[B_WAK])) begin
        w[B_ACT] = 1'b1;
      end
    end
    nxt = w;
    if (hw_kill) begin
      nxt[B_DED] = 1'b1;
      nxt[B_ACT] = 1'b0;
    end
    if (hw_stop)       nxt[B_ACT] = 1'b0;
    if (hw_fetch)      nxt[B_WAK] = 1'b0;
    if (hw_advance)    nxt[B_BT]  = hw_taken;
    if (hw_flush_done) nxt[B_FLU] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= '0;
      flush_req <= 1'b0;
      kick      <= 1'b0;
    end else begin
      st        <= nxt;
      flush_req <= w_flush;
      kick      <= ctl_wr && nxt[B_ACT];
    end
  end

  assign status_o  = st;
  assign bus_rdata = (bus_addr == A_CTL || bus_addr == A_STA) ? {16'h0, st} : 32'h0;

  p_active_needs_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st[B_ACT] |-> (st[B_RUN] && !st[B_PAU]));
  p_inactive_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (flush_req || (st[B_RUN] && !st[B_PAU])));
  p_run_sw_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> $stable(st[B_RUN]));
  p_unused_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st[9] == 1'b0) && (st[7:4] == 4'h0));
  p_kick_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
    kick |-> st[B_ACT]);
  p_kill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hw_kill |=> (st[B_DED] && !st[B_ACT]));
  p_fetch_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hw_fetch |=> !st[B_WAK]);
  p_flush_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hw_flush_done |=> !st[B_FLU]);
endmodule

// File: tb/dma_chan_ctl_test.sv
module dma_chan_ctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic hw_kill = 0, hw_stop = 0, hw_fetch = 0, hw_advance = 0, hw_taken = 0, hw_flush_done = 0;
  logic [15:0] status_o;
  logic flush_req, kick;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  dma_chan_ctl #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_kill(hw_kill),
    .hw_stop(hw_stop), .hw_fetch(hw_fetch), .hw_advance(hw_advance),
    .hw_taken(hw_taken), .hw_flush_done(hw_flush_done), .status_o(status_o),
    .flush_req(flush_req), .kick(kick));

  always #(CLK_PERIOD/2) clk = ~clk;

  bit mrun, mpau, mflu, mwak, mded, mact, mbt, mfr, mkick, wr, fl;
  bit [3:0] mdev;
  bit [15:0] mk, vl;

  function automatic logic [15:0] mstat();
    return {mrun, mpau, mflu, mwak, mded, mact, 1'b0, mbt, 4'h0, mdev};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      {mrun, mpau, mflu, mwak, mded, mact, mbt, mfr, mkick} = '0;
      mdev = '0;
    end else begin
      wr = bus_wr && (bus_addr == 0);
      mk = bus_wdata[31:16];
      vl = bus_wdata[15:0];
      fl = 0;
      if (wr) begin
        if (mk[15]) begin
          if (vl[15]) mrun = 1;
          else begin mrun = 0; mded = 0; end
        end
        if (mk[14]) mpau = vl[14];
        if (mk[12] && vl[12] && mrun) mwak = 1;
        if (mk[13] && vl[13]) begin mflu = 1; fl = 1; end
        for (int i = 0; i < 4; i++) if (mk[i]) mdev[i] = vl[i];
        if (mpau || !mrun) begin mact = 0; fl = 1; end
        else if (mk[15] || mk[14] || (mk[12] && vl[12])) mact = 1;
      end
      if (hw_kill) begin mded = 1; mact = 0; end
      if (hw_stop) mact = 0;
      if (hw_fetch) mwak = 0;
      if (hw_advance) mbt = hw_taken;
      if (hw_flush_done) mflu = 0;
      mfr = fl;
      mkick = wr && mact;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk("R2 status vs model", {16'h0, status_o}, {16'h0, mstat()});
    chk("R4/R7 flush_req vs model", {31'h0, flush_req}, {31'h0, mfr});
    chk("R8 kick vs model", {31'h0, kick}, {31'h0, mkick});
    chk("R11 read vs model", bus_rdata,
        (bus_addr == 0 || bus_addr == 1) ? {16'h0, mstat()} : 32'h0);
  end

  task automatic op(bit w, int a, logic [31:0] d, bit [5:0] ev);
    @(posedge clk); #1;
    bus_wr = w; bus_addr = AW'(a); bus_wdata = d;
    {hw_flush_done, hw_taken, hw_advance, hw_fetch, hw_stop, hw_kill} = ev;
    @(posedge clk); #1;
    bus_wr = 0; bus_addr = '0;
    {hw_flush_done, hw_taken, hw_advance, hw_fetch, hw_stop, hw_kill} = '0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk("R1 reset status", {16'h0, status_o}, 32'h0);
    chk("R1 reset read", bus_rdata, 32'h0);
    chk("R1 reset pulses", {30'h0, flush_req, kick}, 32'h0);
    op(1, 0, 32'h8000_8000, 0);
    chk("R5 run sets active", {16'h0, status_o}, 32'h8400);
    chk("R8 kick on activate", {31'h0, kick}, 32'h1);
    op(1, 0, 32'h0FF0_0FF0, 0);
    chk("R2 hw-owned mask ignored", {16'h0, status_o}, 32'h8400);
    op(1, 0, 32'h4000_4000, 0);
    chk("R4 pause clears active", {16'h0, status_o}, 32'hC000);
    chk("R4 pause flush", {31'h0, flush_req}, 32'h1);
    op(1, 0, 32'h4000_0000, 0);
    chk("R5 unpause sets active", {16'h0, status_o}, 32'h8400);
    op(0, 0, 0, 6'b000010);
    chk("R9 stop clears active", {16'h0, status_o}, 32'h8000);
    op(1, 0, 32'h1000_1000, 0);
    chk("R6 wake with run", {16'h0, status_o}, 32'h9400);
    op(0, 0, 0, 6'b000100);
    chk("R6 fetch clears wake", {16'h0, status_o}, 32'h8400);
    op(0, 0, 0, 6'b000001);
    chk("R9 kill", {16'h0, status_o}, 32'h8800);
    op(1, 0, 32'h8000_0000, 0);
    chk("R3 run clear clears dead", {16'h0, status_o}, 32'h0);
    chk("R4 stop flush", {31'h0, flush_req}, 32'h1);
    op(1, 0, 32'h1000_1000, 0);
    chk("R6 wake without run", {16'h0, status_o}, 32'h0);
    op(1, 0, 32'h2000_2000, 0);
    chk("R7 flush bit", {16'h0, status_o}, 32'h2000);
    chk("R7 flush req", {31'h0, flush_req}, 32'h1);
    op(0, 0, 0, 6'b000000);
    chk("R7 flush bit held", {16'h0, status_o}, 32'h2000);
    op(0, 0, 0, 6'b100000);
    chk("R7 flush done", {16'h0, status_o}, 32'h0);
    op(1, 0, 32'h000F_0005, 0);
    chk("R2 device bits", {16'h0, status_o}, 32'h0005);
    op(0, 0, 0, 6'b011000);
    chk("R10 branch taken", {16'h0, status_o}, 32'h0105);
    op(0, 0, 0, 6'b001000);
    chk("R10 sequential advance", {16'h0, status_o}, 32'h0005);
    op(1, 1, 32'hFFFF_FFFF, 0);
    chk("R11 status write ignored", {16'h0, status_o}, 32'h0005);
    op(1, 3, 32'hFFFF_FFFF, 0);
    chk("R11 other write ignored", {16'h0, status_o}, 32'h0005);
    @(posedge clk); #1 bus_addr = 1;
    #1 chk("R11 status read", bus_rdata, 32'h0005);
    bus_addr = 3;
    #1 chk("R11 other read", bus_rdata, 32'h0);
    bus_addr = 0;
    op(1, 0, 32'h8000_8000, 6'b000001);
    chk("R12 kill over write", {16'h0, status_o}, 32'h8805);
    chk("R12 no kick", {31'h0, kick}, 32'h0);
    for (int i = 0; i < 4000; i++) begin
      @(posedge clk); #1;
      bus_wr = $urandom_range(0, 1);
      bus_addr = AW'($urandom_range(0, 3));
      bus_wdata = $urandom;
      hw_kill = ($urandom_range(0, 9) == 0);
      hw_stop = ($urandom_range(0, 7) == 0);
      hw_fetch = ($urandom_range(0, 3) == 0);
      hw_advance = ($urandom_range(0, 3) == 0);
      hw_taken = $urandom_range(0, 1);
      hw_flush_done = ($urandom_range(0, 3) == 0);
    end
    @(posedge clk); #1;
    bus_wr = 0;
    {hw_flush_done, hw_taken, hw_advance, hw_fetch, hw_stop, hw_kill} = '0;
    repeat (2) @(posedge clk);
    #2 finish_run();
  end
endmodule